// File: doc/BRIEF.md
# Edge-Triggered Interrupt Gate

This block sits next to a small in-order processor pipeline and decides the cycle in which an external interrupt is accepted. The interrupt pin is asynchronous to the core clock. It passes through a chain of synchronizing flops. A rising edge on the synchronized level sets a sticky pending flag. Holding the pin high does not set the flag again.

A pending request is accepted only at an instruction boundary that is safe to break. Three conditions must hold in the same cycle:
- the pipeline-advance strobe is high;
- the global interrupt-enable bit from the machine status register is set;
- the instruction crossing the boundary is not an immediate-prefix instruction, because a prefix must stay joined to the instruction that consumes it.

In the accepting cycle the block raises a one-cycle take pulse toward the pipeline. In the same cycle it raises a request to clear the enable bit, so that interrupts do not nest. The pending flag clears on the next edge. Fetching the vector and saving the return address belong to the pipeline.

Top module: `irq_gate`

## Requirements
- R1: While the active-low reset is asserted, and after it is released, all internal state is cleared. With no new rising edge on the pin after release, the take output stays low, even if an edge was pending before reset.
- R2: Take this case: the pin rises just after clock edge n; enable is set; advance is high; the prefix flag is low. Then the take output is high during the cycle after edge n+3 (a three-cycle latency with the default two-stage synchronizer), and low in every other cycle.
- R3: A pin that stays high for many cycles produces exactly one take pulse. Only a low-to-high transition of the synchronized level counts.
- R4: Take is never high while enable is low. A rising edge that arrives while enable is low stays pending for any number of cycles. It is taken combinationally in the first cycle in which enable is high, advance is high and the prefix flag is low.
- R5: Take is never high while advance is low. A pending request waits for advance, and take rises in the same cycle advance goes high.
- R6: Take is never high in a cycle where the prefix flag is high. With advance held high, one prefix cycle delays the take to 4 cycles after the pin edge, and two back-to-back prefix cycles delay it to 5.
- R7: A take pulse lasts one cycle and clears the pending flag. With enable left high, no further take occurs until a new rising edge.
- R8: The enable-clear request output is high in exactly the cycles in which take is high.

Reset detail for R1: the synchronizer flops reset to low. A pin that is already high when reset is released therefore reaches the edge detector as a low-to-high change, the same as any other rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_pin_i | input | 1 | Asynchronous external interrupt line |
| ie_i | input | 1 | Global interrupt-enable bit from the status register |
| adv_i | input | 1 | Pipeline advances across an instruction boundary this cycle |
| imm_prefix_i | input | 1 | Instruction crossing the boundary is an immediate prefix |
| take_o | output | 1 | One-cycle pulse: accept the interrupt at this boundary |
| ie_clr_o | output | 1 | Request to clear the enable bit, same cycle as take |

## Verification
Each stimulus pattern checks the cycle of the take pulse exactly against a cycle number the bench predicts, so it separates a correct gate from one that is early, late or repeated.
- A short pin pulse with every gate condition open fixes the base three-cycle latency.
- A long high level separates edge detection from level sensing.
- Holding enable or advance low for long stretches and then opening it checks that the flag is sticky and that release is immediate.
- One or two prefix cycles at the boundary give the four- and five-cycle cases.
- A reset in the middle shows that a pending request is discarded.

// File: rtl/irqg_pkg.sv
package irqg_pkg;

    // State kept by the edge tracker: last synchronized level and pending flag
    typedef struct packed {
        logic prev;
        logic pend;
    } irqg_track_t;

    localparam irqg_track_t IRQG_TRACK_RST = '{prev: 1'b0, pend: 1'b0};

endpackage

// File: rtl/irqg_sync.sv
module irqg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = async_i;
        end else begin : g_multi
            always_comb chain_d = {chain_q[LAST-1:0], async_i};
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    assign sync_o = chain_q[LAST];
endmodule

// File: rtl/irqg_track.sv
module irqg_track
    import irqg_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic level_i,
    input  logic take_i,
    output logic rise_o,
    output logic pend_o
);
    irqg_track_t st_d, st_q;
    logic        rise;

    always_comb begin
        st_d = st_q;
        rise = level_i & ~st_q.prev;
        st_d.prev = level_i;
        // a new edge wins over the clear caused by a take in the same cycle
        st_d.pend = (st_q.pend & ~take_i) | rise;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= IRQG_TRACK_RST;
        else         st_q <= st_d;
    end

    assign rise_o = rise;
    assign pend_o = st_q.pend;
endmodule

// File: rtl/irqg_gate.sv
module irqg_gate (
    input  logic pend_i,
    input  logic ie_i,
    input  logic adv_i,
    input  logic imm_prefix_i,
    output logic take_o
);
    logic safe_boundary;

    always_comb begin
        safe_boundary = adv_i & ~imm_prefix_i;
        take_o        = pend_i & ie_i & safe_boundary;
    end
endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic irq_pin_i,
    input  logic ie_i,
    input  logic adv_i,
    input  logic imm_prefix_i,
    output logic take_o,
    output logic ie_clr_o
);
    logic level_w;
    logic rise_w;
    logic pend_w;
    logic take_w;

    irqg_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (irq_pin_i),
        .sync_o  (level_w)
    );

    irqg_track i_track (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .level_i (level_w),
        .take_i  (take_w),
        .rise_o  (rise_w),
        .pend_o  (pend_w)
    );

    irqg_gate i_gate (
        .pend_i       (pend_w),
        .ie_i         (ie_i),
        .adv_i        (adv_i),
        .imm_prefix_i (imm_prefix_i),
        .take_o       (take_w)
    );

    assign take_o   = take_w;
    assign ie_clr_o = take_w;
endmodule

// File: rtl/irq_gate_chk.sv
module irq_gate_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic ie_i,
    input logic adv_i,
    input logic imm_prefix_i,
    input logic take_o,
    input logic ie_clr_o,
    input logic rise_w,
    input logic pend_w
);
    assert_take_needs_ie_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take_o |-> ie_i);

    assert_take_needs_adv_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take_o |-> adv_i);

    assert_no_take_on_prefix_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take_o |-> !imm_prefix_i);

    assert_take_clears_pend_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (take_o && !rise_w) |=> !pend_w);

    assert_pend_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_w && !take_o) |=> pend_w);

    assert_edge_latches_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_w |=> pend_w);

    assert_clr_tracks_take_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take_o == ie_clr_o);

    always @(negedge clk_i) begin
        if (!rst_ni) begin
            assert_quiet_in_reset_R1: assert (!take_o && !pend_w);
        end
    end
endmodule

bind irq_gate irq_gate_chk i_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ie_i         (ie_i),
    .adv_i        (adv_i),
    .imm_prefix_i (imm_prefix_i),
    .take_o       (take_o),
    .ie_clr_o     (ie_clr_o),
    .rise_w       (rise_w),
    .pend_w       (pend_w)
);

// File: tb/test_irq_gate.sv
module test_irq_gate;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pin = 1'b0, ie = 1'b0, adv = 1'b0, imm = 1'b0;
    logic take, ie_clr;
    int   cyc = 0;
    int   checks = 0, errors = 0;

    typedef struct { int at; string req; } exp_t;
    exp_t exp_q[$];

    always #10 clk = ~clk;   // 50 MHz
    always @(posedge clk) cyc <= cyc + 1;

    irq_gate i_irq_gate (
        .clk_i(clk), .rst_ni(rst_n), .irq_pin_i(pin), .ie_i(ie),
        .adv_i(adv), .imm_prefix_i(imm), .take_o(take), .ie_clr_o(ie_clr)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic expect_take(input int at, input string req);
        exp_t e;
        e.at = at; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic drain(input string req);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL %s: %0d expected take pulses missing, expected 0", req, exp_q.size());
            exp_q.delete();
        end
    endtask

    task automatic report;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (take !== ie_clr) begin
                checks++; errors++;
                $display("FAIL R8: ie_clr=%b expected %b", ie_clr, take);
            end
            if (take === 1'b1) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R7: unexpected take at cycle %0d, expected none", cyc);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (e.at != cyc) begin
                        errors++;
                        $display("FAIL %s: take at cycle %0d, expected %0d", e.req, cyc, e.at);
                    end
                    if (ie_clr !== 1'b1) begin
                        errors++;
                        $display("FAIL R8: ie_clr=%b expected 1", ie_clr);
                    end
                end
            end
        end
    end

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        report();
    end

    initial begin
        int n;
        step(3);
        @(negedge clk);
        checks++;
        if (take !== 1'b0 || ie_clr !== 1'b0) begin
            errors++;
            $display("FAIL R1: take=%b clr=%b during reset, expected 0 0", take, ie_clr);
        end
        step(1);
        rst_n = 1'b1;
        step(4);

        // R2: base latency
        ie = 1; adv = 1;
        n = cyc; pin = 1; expect_take(n + 3, "R2");
        step(2); pin = 0;
        step(10); drain("R2");

        // R3: long level gives one pulse
        n = cyc; pin = 1; expect_take(n + 3, "R3");
        step(40); pin = 0;
        step(10); drain("R3");

        // R4: edge while disabled stays pending
        ie = 0;
        pin = 1; step(3); pin = 0;
        step(30);
        drain("R4 held");
        ie = 1; expect_take(cyc, "R4");
        step(1); ie = 0; step(5); ie = 1;
        step(10); drain("R4");

        // R5: waits for advance
        adv = 0;
        pin = 1; step(3); pin = 0;
        step(20);
        drain("R5 held");
        adv = 1; expect_take(cyc, "R5");
        step(10); drain("R5");

        // R6: one prefix cycle at the boundary
        n = cyc; pin = 1; expect_take(n + 4, "R6 one");
        step(3); imm = 1; pin = 0;
        step(1); imm = 0;
        step(10); drain("R6 one");

        // R6: two back-to-back prefix cycles
        n = cyc; pin = 1; expect_take(n + 5, "R6 two");
        step(3); imm = 1; pin = 0;
        step(2); imm = 0;
        step(10); drain("R6 two");

        // R7: two separate edges give two pulses, nothing in between
        n = cyc; pin = 1; expect_take(n + 3, "R7 first");
        step(2); pin = 0; step(8);
        n = cyc; pin = 1; expect_take(n + 3, "R7 second");
        step(2); pin = 0; step(15);
        drain("R7");

        // R1: reset drops a pending request
        ie = 0;
        pin = 1; step(3); pin = 0; step(5);
        rst_n = 0; step(3);
        @(negedge clk);
        checks++;
        if (take !== 1'b0) begin
            errors++;
            $display("FAIL R1: take=%b in reset, expected 0", take);
        end
        step(1); rst_n = 1; step(2);
        ie = 1; step(20);
        drain("R1");

        report();
    end
endmodule